// File: doc/BRIEF.md
# Push-Button Power-Cycle Reset Sequencer

This block watches an active-low push-button. After the button has been held down long enough, it briefly opens the load switch between the battery and the system rail. Everything powered from that rail then goes through a genuine power-on reset. Before the switch is opened, the charger converter is commanded into high impedance, so the rail really collapses even when an adapter is plugged in. When the switch closes again, a one-cycle pulse returns the configuration registers to their defaults.

Two configuration bits gate the whole function: a reset-enable bit and a switch-disable bit. A third bit chooses whether a reset may begin while an adapter is attached or must wait for the adapter to be unplugged. A fourth bit is the host's high-impedance request; its value when the sequence starts decides whether the converter stays parked in high impedance afterwards. The hold time and the off time are parameters counted in clock cycles.

Top module: `pb_reset_seq`

## Requirements
- R1: No sequence starts (busy stays 0) while cfgRstEn is 0 or cfgSwDis is 1.
- R2: With the function enabled and the adapter condition met, busy rises at the edge that samples btnN low for the (HOLD_CYC+1)-th consecutive time.
- R3: If btnN is sampled high before the hold time is met, the hold count restarts from zero.
- R4: swEnable is low for exactly OFF_CYC consecutive cycles, beginning one cycle after busy rises.
- R5: hizCmd is 1 in the cycle busy rises, while swEnable is still 1, and stays 1 through the whole off interval.
- R6: With cfgRstWithAdapter = 0, a met hold does not start a sequence while adapterIn is 1. The sequence starts on the first edge where adapterIn is 0 and the button is still held.
- R7: With cfgRstWithAdapter = 1, a sequence starts after the hold time even while adapterIn is 1.
- R8: regResetPulse is high for exactly one cycle, the cycle in which swEnable returns to 1. busy is 0 in that cycle.
- R9: The value of cfgHizReq sampled at the start edge is held after completion. If it was 1, hizCmd stays 1 until the next sequence completes, whatever cfgHizReq does later.
- R10: Button activity during a sequence is ignored. Another sequence needs btnN to be sampled high and then held low for the hold time again.
- R11: Outside the off interval swEnable equals the inverse of cfgSwDis. When idle with no held request, hizCmd equals cfgHizReq. After reset, busy and regResetPulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| btnN | input | 1 | Debounced push-button, low while pressed |
| adapterIn | input | 1 | Adapter present flag |
| cfgRstEn | input | 1 | Power-cycle reset function enable |
| cfgSwDis | input | 1 | Load switch forced off |
| cfgRstWithAdapter | input | 1 | Allow reset while an adapter is present |
| cfgHizReq | input | 1 | Host request for converter high impedance |
| swEnable | output | 1 | Load switch on |
| hizCmd | output | 1 | Converter high-impedance command |
| regResetPulse | output | 1 | One-cycle register default restore |
| busy | output | 1 | Sequence in progress, switch not yet re-enabled |

## Verification
The off-interval length assertion counts cycles in which busy is high and swEnable is low. It therefore assumes cfgSwDis stays 0 from the start edge to completion. The stimulus changes configuration bits only while the block is idle, and it never changes them during a sequence. The start-gating properties assume the inputs are synchronous to clk. The bench changes them one time unit after a rising edge.

// File: rtl/pb_reset_seq_pkg.sv
package pb_reset_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HIZ  = 2'd1,
    SEQ_OFF  = 2'd2,
    SEQ_DONE = 2'd3
  } seqState_t;

  typedef struct packed {
    logic holdInc;     // count another low sample
    logic holdClr;     // restart the hold count
    logic offInc;      // advance the off-interval count
    logic offClr;      // restart the off-interval count
    logic hizCapture;  // sample the host hi-z request at start
    logic hizCommit;   // make the captured request effective
  } seqStrobe_t;

endpackage

// File: rtl/pb_reset_seq_dp.sv
module pb_reset_seq_dp
  import pb_reset_seq_pkg::*;
#(
  parameter int HOLD_CYC = 40,
  parameter int OFF_CYC  = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  input  logic       cfgHizReq,
  output logic       holdMet,
  output logic       offLast,
  output logic       hizHeld
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int OW = $clog2(OFF_CYC + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);
  localparam logic [OW-1:0] OFF_MAX  = OW'(OFF_CYC - 1);

  logic [HW-1:0] holdCnt;
  logic [OW-1:0] offCnt;
  logic          hizCap;

  assign holdMet = (holdCnt == HOLD_MAX);
  assign offLast = (offCnt == OFF_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (stb.holdClr) begin
      holdCnt <= '0;
    end else if (stb.holdInc && !holdMet) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (stb.offClr) begin
      offCnt <= '0;
    end else if (stb.offInc) begin
      offCnt <= offCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hizCap  <= 1'b0;
      hizHeld <= 1'b0;
    end else begin
      if (stb.hizCapture) hizCap  <= cfgHizReq;
      if (stb.hizCommit)  hizHeld <= hizCap;
    end
  end

endmodule

// File: rtl/pb_reset_seq_ctrl.sv
module pb_reset_seq_ctrl
  import pb_reset_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnN,
  input  logic       adapterIn,
  input  logic       cfgRstEn,
  input  logic       cfgSwDis,
  input  logic       cfgRstWithAdapter,
  input  logic       holdMet,
  input  logic       offLast,
  output seqStrobe_t stb,
  output logic       inSeq,
  output logic       swOff,
  output logic       doneStb
);
  seqState_t state, stateNxt;
  logic      armed;
  logic      enabled;
  logic      pressing;
  logic      startGo;

  assign enabled  = cfgRstEn && !cfgSwDis;
  assign pressing = (state == SEQ_IDLE) && enabled && armed && !btnN;
  assign startGo  = pressing && holdMet && (cfgRstWithAdapter || !adapterIn);

  always_comb begin
    stateNxt = state;
    unique case (state)
      SEQ_IDLE: if (startGo) stateNxt = SEQ_HIZ;
      SEQ_HIZ:  stateNxt = SEQ_OFF;
      SEQ_OFF:  if (offLast) stateNxt = SEQ_DONE;
      SEQ_DONE: stateNxt = SEQ_IDLE;
      default:  stateNxt = SEQ_IDLE;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.holdInc    = pressing;
    stb.holdClr    = !pressing || startGo;
    stb.offInc     = (state == SEQ_OFF);
    stb.offClr     = (state != SEQ_OFF);
    stb.hizCapture = startGo;
    stb.hizCommit  = (state == SEQ_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startGo)   armed <= 1'b0;
      else if (btnN) armed <= 1'b1;
    end
  end

  assign inSeq   = (state == SEQ_HIZ) || (state == SEQ_OFF);
  assign swOff   = (state == SEQ_OFF);
  assign doneStb = (state == SEQ_DONE);

endmodule

// File: rtl/pb_reset_seq.sv
module pb_reset_seq
  import pb_reset_seq_pkg::*;
#(
  parameter int HOLD_CYC = 40,
  parameter int OFF_CYC  = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  input  logic adapterIn,
  input  logic cfgRstEn,
  input  logic cfgSwDis,
  input  logic cfgRstWithAdapter,
  input  logic cfgHizReq,
  output logic swEnable,
  output logic hizCmd,
  output logic regResetPulse,
  output logic busy
);
  seqStrobe_t stb;
  logic holdMet, offLast, hizHeld;
  logic inSeq, swOff, doneStb;

  pb_reset_seq_ctrl u_ctrl (
    .clk               (clk),
    .rstN              (rstN),
    .btnN              (btnN),
    .adapterIn         (adapterIn),
    .cfgRstEn          (cfgRstEn),
    .cfgSwDis          (cfgSwDis),
    .cfgRstWithAdapter (cfgRstWithAdapter),
    .holdMet           (holdMet),
    .offLast           (offLast),
    .stb               (stb),
    .inSeq             (inSeq),
    .swOff             (swOff),
    .doneStb           (doneStb)
  );

  pb_reset_seq_dp #(
    .HOLD_CYC (HOLD_CYC),
    .OFF_CYC  (OFF_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgHizReq (cfgHizReq),
    .holdMet   (holdMet),
    .offLast   (offLast),
    .hizHeld   (hizHeld)
  );

  assign swEnable      = !swOff && !cfgSwDis;
  assign hizCmd        = inSeq || cfgHizReq || hizHeld;
  assign regResetPulse = doneStb;
  assign busy          = inSeq;

endmodule

// File: rtl/pb_reset_seq_chk.sv
module pb_reset_seq_chk #(
  parameter int OFF_CYC = 25
) (
  input logic clk,
  input logic rstN,
  input logic btnN,
  input logic adapterIn,
  input logic cfgRstEn,
  input logic cfgSwDis,
  input logic cfgRstWithAdapter,
  input logic swEnable,
  input logic hizCmd,
  input logic regResetPulse,
  input logic busy
);
  int offRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 offRun <= 0;
    else if (busy && !swEnable) offRun <= offRun + 1;
    else                       offRun <= 0;
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cfgRstEn) && !$past(cfgSwDis)));                      // R1
  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(btnN));                                                // R2
  AST_ADAPTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cfgRstWithAdapter) || !$past(adapterIn)));            // R6
  AST_HIZ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !cfgSwDis) |-> (swEnable && hizCmd));                         // R5
  AST_OFF_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !swEnable) |-> hizCmd);                                              // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regResetPulse |=> !regResetPulse);                                            // R8
  AST_PULSE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    regResetPulse |-> (!busy && $past(busy)));                                    // R8
  AST_OFF_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    regResetPulse |-> (offRun == OFF_CYC));                                       // R4

endmodule

bind pb_reset_seq pb_reset_seq_chk #(.OFF_CYC(OFF_CYC)) u_chk (
  .clk               (clk),
  .rstN              (rstN),
  .btnN              (btnN),
  .adapterIn         (adapterIn),
  .cfgRstEn          (cfgRstEn),
  .cfgSwDis          (cfgSwDis),
  .cfgRstWithAdapter (cfgRstWithAdapter),
  .swEnable          (swEnable),
  .hizCmd            (hizCmd),
  .regResetPulse     (regResetPulse),
  .busy              (busy)
);

// File: tb/pb_reset_seq_bench.sv
`timescale 1ns/1ps
module pb_reset_seq_bench;
  localparam int HOLD = 40;
  localparam int OFF  = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnN = 1'b1;
  logic adapterIn = 1'b0;
  logic cfgRstEn = 1'b1;
  logic cfgSwDis = 1'b0;
  logic cfgRstWithAdapter = 1'b0;
  logic cfgHizReq = 1'b0;
  logic swEnable, hizCmd, regResetPulse, busy;

  int compared = 0;
  int mismatched = 0;

  // behavioural reference state
  int  mPhase = 0;     // 0 idle, 1 hi-z lead, 2 switch off, 3 restore
  int  mLow = 0;
  int  mOff = 0;
  bit  mArmed = 0;
  bit  mHizCap = 0;
  bit  mHizHold = 0;

  // bench observations
  int  pulseCnt = 0;
  int  offSeen = 0;
  int  lastOff = 0;
  int  busyRises = 0;
  bit  busyPrev = 0;

  always #10 clk = ~clk;

  pb_reset_seq #(.HOLD_CYC(HOLD), .OFF_CYC(OFF)) u_pb_reset_seq (
    .clk (clk), .rstN (rstN), .btnN (btnN), .adapterIn (adapterIn),
    .cfgRstEn (cfgRstEn), .cfgSwDis (cfgSwDis),
    .cfgRstWithAdapter (cfgRstWithAdapter), .cfgHizReq (cfgHizReq),
    .swEnable (swEnable), .hizCmd (hizCmd),
    .regResetPulse (regResetPulse), .busy (busy)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mLow = 0; mOff = 0; mArmed = 0; mHizCap = 0; mHizHold = 0;
    end else begin
      case (mPhase)
        0: begin
          if (!btnN && mArmed && cfgRstEn && !cfgSwDis) begin
            if (mLow >= HOLD && (cfgRstWithAdapter || !adapterIn)) begin
              mPhase = 1; mArmed = 0; mHizCap = cfgHizReq; mLow = 0;
            end else if (mLow < HOLD) mLow++;
          end else begin
            mLow = 0;
          end
          if (btnN) mArmed = 1;
        end
        1: begin mPhase = 2; mOff = 0; end
        2: begin if (mOff == OFF - 1) mPhase = 3; else mOff++; end
        default: begin mPhase = 0; mHizHold = mHizCap; end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      bit eSw, eHiz, ePulse, eBusy;
      eSw    = (mPhase != 2) && !cfgSwDis;
      eHiz   = (mPhase == 1) || (mPhase == 2) || cfgHizReq || mHizHold;
      ePulse = (mPhase == 3);
      eBusy  = (mPhase == 1) || (mPhase == 2);
      check(swEnable == eSw, "R4 swEnable", swEnable, eSw);
      check(hizCmd == eHiz, "R5 hizCmd", hizCmd, eHiz);
      check(regResetPulse == ePulse, "R8 regResetPulse", regResetPulse, ePulse);
      check(busy == eBusy, "R2 busy", busy, eBusy);
      if (busy && !swEnable) offSeen++;
      if (regResetPulse) begin pulseCnt++; lastOff = offSeen; offSeen = 0; end
      if (busy && !busyPrev) busyRises++;
      busyPrev = busy;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic press(input int n);
    btnN = 1'b0; cyc(n); btnN = 1'b1; cyc(2);
  endtask

  initial begin
    int r0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R11 reset state
    check(busy == 0 && regResetPulse == 0, "R11 reset outputs", busy, 0);
    check(swEnable == 1 && hizCmd == 0, "R11 idle outputs", swEnable, 1);

    // R3: short presses never accumulate
    r0 = busyRises;
    press(20); press(30); press(HOLD - 1);
    check(busyRises == r0, "R3 short presses", busyRises, r0);

    // R2/R4/R8: full press, no adapter
    press(HOLD + OFF + 10);
    cyc(5);
    check(pulseCnt == 1, "R8 pulse count", pulseCnt, 1);
    check(lastOff == OFF, "R4 off length", lastOff, OFF);

    // R10: long hold yields a single sequence
    r0 = pulseCnt;
    press(3 * (HOLD + OFF));
    check(pulseCnt == r0 + 1, "R10 one per press", pulseCnt, r0 + 1);

    // R6: adapter blocks start until removed
    adapterIn = 1'b1; r0 = busyRises;
    btnN = 1'b0; cyc(HOLD + 30);
    check(busyRises == r0, "R6 blocked by adapter", busyRises, r0);
    adapterIn = 1'b0; cyc(OFF + 10);
    check(busyRises == r0 + 1, "R6 starts after removal", busyRises, r0 + 1);
    btnN = 1'b1; cyc(3);

    // R7: adapter allowed
    adapterIn = 1'b1; cfgRstWithAdapter = 1'b1; r0 = pulseCnt;
    press(HOLD + OFF + 10);
    check(pulseCnt == r0 + 1, "R7 start with adapter", pulseCnt, r0 + 1);
    adapterIn = 1'b0; cfgRstWithAdapter = 1'b0;

    // R1: disabled function
    cfgRstEn = 1'b0; r0 = busyRises;
    press(HOLD + 20);
    check(busyRises == r0, "R1 reset disabled", busyRises, r0);
    cfgRstEn = 1'b1; cfgSwDis = 1'b1;
    press(HOLD + 20);
    check(busyRises == r0, "R1 switch disabled", busyRises, r0);
    check(swEnable == 0, "R11 switch forced off", swEnable, 0);
    cfgSwDis = 1'b0; cyc(1);

    // R9: hi-z request held across the reset
    cfgHizReq = 1'b1;
    press(HOLD + OFF + 10);
    cfgHizReq = 1'b0; cyc(3);
    check(hizCmd == 1, "R9 hi-z held", hizCmd, 1);
    press(HOLD + OFF + 10);
    check(hizCmd == 0, "R9 hi-z released", hizCmd, 0);
    check(lastOff == OFF, "R4 off length again", lastOff, OFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #3_000_000;
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule